// File: doc/BRIEF.md
# Forward-Edge Landing Pad Tracker

This block follows the expected-landing-pad state of one hart for forward-edge control-flow integrity. It watches the retire stream one instruction per cycle. For each retired instruction it sees the privilege mode, the virtualization flag and whether the instruction is an indirect jump, a landing pad, a trap entry or a return from trap (machine or supervisor). Once an indirect jump retires in a mode where enforcement is on, the next retired instruction must be a landing pad. If it is not, the block raises a dedicated integrity-check fault with a fixed cause code. It does not signal an illegal-instruction trap in that case.

Each privilege mode takes its enable from its own environment-configuration bit. User mode follows the supervisor-level bit. Native supervisor mode follows the machine-level bit. Virtualized supervisor mode follows the hypervisor-level bit. On a trap the block saves the current state into a fixed bit of the status image. On the matching return it restores the state from that bit and clears the bit. The status register itself lives elsewhere. The block receives its image, applies the save and clear updates, and hands back the updated image one cycle later for the CSR file to store.

Top module: `lpe_tracker`

## Requirements
- R1: After synchronous reset, `elp_o`, `fault_o`, `fault_cause_o` and `mstatus_o` are all zero.
- R2: An indirect jump (`rt_ijmp`) retiring with `elp_o`=0 sets `elp_o` to 1 on the next cycle when enforcement is on for its mode. The enable is `menv_lpe` for supervisor mode (`rt_priv`=2'b01, `rt_virt`=0) and `henv_lpe` for supervisor mode with `rt_virt`=1. Machine mode (`rt_priv`=2'b11) is never enforced.
- R3: For user mode (`rt_priv`=2'b00) the enable is `senv_lpe` alone. It sets `elp_o` even when `menv_lpe`=0, and it does not set `elp_o` when `senv_lpe`=0 even if `menv_lpe`=1.
- R4: A landing pad (`rt_lpad`) retiring while `elp_o`=1 clears `elp_o` on the next cycle without a fault.
- R5: Any other non-trap instruction retiring while `elp_o`=1 raises `fault_o` for exactly one cycle with `fault_cause_o`=FAULT_CAUSE (default 18). `elp_o` reads 0 in that same cycle.
- R6: A trap entry (`rt_trap`) with a target other than supervisor copies `elp_o` into bit MPELP_BIT (default 41) of `mstatus_o` and clears `elp_o`, with no fault.
- R7: A trap entry with target supervisor (`rt_tgt`=2'b01) copies `elp_o` into bit SPELP_BIT (default 23) of `mstatus_o` and clears `elp_o`.
- R8: A machine return (`rt_mret`) loads `elp_o` from `mstatus_i[MPELP_BIT]` and clears that bit in `mstatus_o`. A supervisor return (`rt_sret`) does the same with SPELP_BIT. The target mode is given by `rt_tgt` and `rt_tgt_virt`.
- R9: A return into a mode whose enable is off leaves `elp_o` at 0 whatever the saved bit holds, and it still clears the saved bit.
- R10: Bits of `mstatus_i` that no event updates appear unchanged on `mstatus_o` one cycle later.
- R11: A cycle with `rt_valid`=0 leaves `elp_o` unchanged and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_valid | input | 1 | An instruction retires this cycle |
| rt_priv | input | 2 | Mode of the retiring instruction (00 U, 01 S, 11 M) |
| rt_virt | input | 1 | Retiring instruction runs virtualized |
| rt_ijmp | input | 1 | Indirect jump or call |
| rt_lpad | input | 1 | Landing pad instruction |
| rt_trap | input | 1 | Trap entry in place of the instruction |
| rt_mret | input | 1 | Machine return |
| rt_sret | input | 1 | Supervisor return |
| rt_tgt | input | 2 | Mode entered by trap or return |
| rt_tgt_virt | input | 1 | Mode entered by a return is virtualized |
| menv_lpe | input | 1 | Machine-level envcfg landing pad enable |
| senv_lpe | input | 1 | Supervisor-level envcfg landing pad enable |
| henv_lpe | input | 1 | Hypervisor-level envcfg landing pad enable |
| mstatus_i | input | XLEN | Current status register image |
| elp_o | output | 1 | Landing pad expected |
| mstatus_o | output | XLEN | Status image with saved-state bits updated |
| fault_o | output | 1 | Integrity-check fault pulse |
| fault_cause_o | output | CAUSE_W | Cause code, valid with `fault_o` |

## Verification
All outputs come from flops. The result of an instruction retired in cycle N is therefore due on the outputs after the clock edge that ends cycle N. The fault pulse is gone one edge later. The bench drives each instruction on a falling edge, waits for the next rising edge and samples one time unit after it. Each check looks at exactly the cycle in which that instruction's update appears. Fault and return cases are followed by a second sample to confirm that the pulse ended and that the saved bit stayed cleared.

// File: rtl/lpe_pkg.sv
package lpe_pkg;
  typedef enum logic [1:0] {
    MODE_U = 2'b00,
    MODE_S = 2'b01,
    MODE_M = 2'b11
  } mode_e;

  typedef enum logic {
    LP_NONE     = 1'b0,
    LP_EXPECTED = 1'b1
  } lp_state_e;
endpackage

// File: rtl/lpe_mode_enable.sv
module lpe_mode_enable
  import lpe_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       virt,
  input  logic       menv_lpe,
  input  logic       senv_lpe,
  input  logic       henv_lpe,
  output logic       enable
);
  always_comb begin
    unique case (mode)
      MODE_U:  enable = senv_lpe;
      MODE_S:  enable = virt ? henv_lpe : menv_lpe;
      default: enable = 1'b0;
    endcase
  end
endmodule

// File: rtl/lpe_step.sv
module lpe_step
  import lpe_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int MPELP_BIT = 41,
  parameter int SPELP_BIT = 23
) (
  input  logic            elp_q,
  input  logic            valid,
  input  logic            ijmp,
  input  logic            lpad,
  input  logic            trap,
  input  logic            mret,
  input  logic            sret,
  input  logic [1:0]      tgt,
  input  logic            en_cur,
  input  logic            en_tgt,
  input  logic [XLEN-1:0] mst_in,
  output logic            elp_d,
  output logic [XLEN-1:0] mst_d,
  output logic            flt_d
);
  always_comb begin
    elp_d = elp_q;
    mst_d = mst_in;
    flt_d = 1'b0;
    if (valid) begin
      if (trap) begin
        if (tgt == MODE_S) mst_d[SPELP_BIT] = elp_q;
        else               mst_d[MPELP_BIT] = elp_q;
        elp_d = LP_NONE;
      end else if (elp_q == LP_EXPECTED) begin
        elp_d = LP_NONE;
        flt_d = !lpad;
      end else if (mret) begin
        elp_d = mst_in[MPELP_BIT] & en_tgt;
        mst_d[MPELP_BIT] = 1'b0;
      end else if (sret) begin
        elp_d = mst_in[SPELP_BIT] & en_tgt;
        mst_d[SPELP_BIT] = 1'b0;
      end else if (ijmp) begin
        elp_d = en_cur;
      end
    end
  end
endmodule

// File: rtl/lpe_tracker.sv
module lpe_tracker
  import lpe_pkg::*;
#(
  parameter int XLEN        = 64,
  parameter int MPELP_BIT   = 41,
  parameter int SPELP_BIT   = 23,
  parameter int CAUSE_W     = 6,
  parameter int FAULT_CAUSE = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rt_valid,
  input  logic [1:0]         rt_priv,
  input  logic               rt_virt,
  input  logic               rt_ijmp,
  input  logic               rt_lpad,
  input  logic               rt_trap,
  input  logic               rt_mret,
  input  logic               rt_sret,
  input  logic [1:0]         rt_tgt,
  input  logic               rt_tgt_virt,
  input  logic               menv_lpe,
  input  logic               senv_lpe,
  input  logic               henv_lpe,
  input  logic [XLEN-1:0]    mstatus_i,
  output logic               elp_o,
  output logic [XLEN-1:0]    mstatus_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] fault_cause_o
);
  localparam logic [CAUSE_W-1:0] CAUSE_CODE = CAUSE_W'(FAULT_CAUSE);

  logic            en_cur, en_tgt, elp_d, flt_d;
  logic [XLEN-1:0] mst_d;

  lpe_mode_enable u_en_cur (
    .mode(rt_priv), .virt(rt_virt), .menv_lpe(menv_lpe),
    .senv_lpe(senv_lpe), .henv_lpe(henv_lpe), .enable(en_cur)
  );

  lpe_mode_enable u_en_tgt (
    .mode(rt_tgt), .virt(rt_tgt_virt), .menv_lpe(menv_lpe),
    .senv_lpe(senv_lpe), .henv_lpe(henv_lpe), .enable(en_tgt)
  );

  lpe_step #(.XLEN(XLEN), .MPELP_BIT(MPELP_BIT), .SPELP_BIT(SPELP_BIT)) u_step (
    .elp_q(elp_o), .valid(rt_valid), .ijmp(rt_ijmp), .lpad(rt_lpad),
    .trap(rt_trap), .mret(rt_mret), .sret(rt_sret), .tgt(rt_tgt),
    .en_cur(en_cur), .en_tgt(en_tgt), .mst_in(mstatus_i),
    .elp_d(elp_d), .mst_d(mst_d), .flt_d(flt_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      elp_o         <= LP_NONE;
      mstatus_o     <= '0;
      fault_o       <= 1'b0;
      fault_cause_o <= '0;
    end else begin
      elp_o         <= elp_d;
      mstatus_o     <= mst_d;
      fault_o       <= flt_d;
      fault_cause_o <= flt_d ? CAUSE_CODE : '0;
    end
  end
endmodule

// File: rtl/lpe_tracker_chk.sv
module lpe_tracker_chk #(
  parameter int XLEN        = 64,
  parameter int MPELP_BIT   = 41,
  parameter int SPELP_BIT   = 23,
  parameter int CAUSE_W     = 6,
  parameter int FAULT_CAUSE = 18
) (
  input logic               clk,
  input logic               rst,
  input logic               rt_valid,
  input logic               rt_lpad,
  input logic               rt_trap,
  input logic               rt_mret,
  input logic [1:0]         rt_tgt,
  input logic               elp_o,
  input logic [XLEN-1:0]    mstatus_o,
  input logic               fault_o,
  input logic [CAUSE_W-1:0] fault_cause_o
);
  assert_fault_clears_R5: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (!elp_o && fault_cause_o == CAUSE_W'(FAULT_CAUSE)));

  assert_fault_single_R5: assert property (@(posedge clk) disable iff (rst)
    fault_o |=> !fault_o);

  assert_missing_pad_R5: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && elp_o && !rt_trap && !rt_lpad) |=> fault_o);

  assert_pad_no_fault_R4: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && elp_o && !rt_trap && rt_lpad) |=> (!fault_o && !elp_o));

  assert_trap_save_m_R6: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && rt_trap && rt_tgt == 2'b11) |=>
      (mstatus_o[MPELP_BIT] == $past(elp_o) && !elp_o && !fault_o));

  assert_trap_save_s_R7: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && rt_trap && rt_tgt == 2'b01) |=>
      (mstatus_o[SPELP_BIT] == $past(elp_o) && !elp_o));

  assert_mret_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (rt_valid && rt_mret && !rt_trap && !elp_o) |=> !mstatus_o[MPELP_BIT]);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rt_valid |=> (elp_o == $past(elp_o) && !fault_o));
endmodule

bind lpe_tracker lpe_tracker_chk #(
  .XLEN(XLEN), .MPELP_BIT(MPELP_BIT), .SPELP_BIT(SPELP_BIT),
  .CAUSE_W(CAUSE_W), .FAULT_CAUSE(FAULT_CAUSE)
) u_chk (
  .clk(clk), .rst(rst), .rt_valid(rt_valid), .rt_lpad(rt_lpad),
  .rt_trap(rt_trap), .rt_mret(rt_mret), .rt_tgt(rt_tgt), .elp_o(elp_o),
  .mstatus_o(mstatus_o), .fault_o(fault_o), .fault_cause_o(fault_cause_o)
);

// File: tb/lpe_tracker_tb.sv
`timescale 1ns/1ps
module lpe_tracker_tb_top;
  localparam int XLEN = 64;
  localparam int MPB  = 41;
  localparam int SPB  = 23;
  localparam int CW   = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, rt_valid, rt_virt, rt_ijmp, rt_lpad, rt_trap, rt_mret, rt_sret;
  logic rt_tgt_virt, menv_lpe, senv_lpe, henv_lpe;
  logic [1:0] rt_priv, rt_tgt;
  logic [XLEN-1:0] mstatus_i, mstatus_o;
  logic elp_o, fault_o;
  logic [CW-1:0] fault_cause_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  lpe_tracker dut_i (
    .clk(clk), .rst(rst), .rt_valid(rt_valid), .rt_priv(rt_priv), .rt_virt(rt_virt),
    .rt_ijmp(rt_ijmp), .rt_lpad(rt_lpad), .rt_trap(rt_trap), .rt_mret(rt_mret),
    .rt_sret(rt_sret), .rt_tgt(rt_tgt), .rt_tgt_virt(rt_tgt_virt),
    .menv_lpe(menv_lpe), .senv_lpe(senv_lpe), .henv_lpe(henv_lpe),
    .mstatus_i(mstatus_i), .elp_o(elp_o), .mstatus_o(mstatus_o),
    .fault_o(fault_o), .fault_cause_o(fault_cause_o)
  );

  // {valid, priv[1:0], virt, ijmp, lpad, menv, senv, henv, exp_elp, exp_fault}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    11'b1_00_0_10_010_1_0, // R3: U jump, senv=1 menv=0 -> expected
    11'b1_00_0_01_010_0_0, // R4: pad clears
    11'b1_00_0_10_100_0_0, // R3: U jump, senv=0 menv=1 -> none
    11'b1_01_0_10_100_1_0, // R2: S jump with menv
    11'b1_01_0_00_100_0_1, // R5: plain instr -> fault
    11'b1_01_1_10_001_1_0, // R2: VS jump with henv
    11'b1_01_1_01_001_0_0, // R4: pad clears
    11'b1_11_0_10_111_0_0, // R2: M never enforced
    11'b1_01_1_10_100_0_0, // R2: VS jump with henv=0
    11'b1_00_0_10_010_1_0, // R3: U jump
    11'b0_00_0_00_010_1_0, // R11: idle holds
    11'b1_00_0_01_010_0_0, // R4: pad clears
    11'b1_00_0_10_010_1_0, // R2: U jump
    11'b1_00_0_10_010_0_1  // R5: jump instead of pad -> fault
  };

  task automatic check(input string what, input logic [XLEN-1:0] got, input logic [XLEN-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0h expected=%0h", what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    rt_valid = 0; rt_priv = 2'b00; rt_virt = 0; rt_ijmp = 0; rt_lpad = 0;
    rt_trap = 0; rt_mret = 0; rt_sret = 0; rt_tgt = 2'b00; rt_tgt_virt = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic retire(input logic [1:0] pr, input logic ij, input logic lp,
                        input logic tr, input logic mr, input logic sr, input logic [1:0] tg);
    @(negedge clk);
    idle_inputs();
    rt_valid = 1; rt_priv = pr; rt_ijmp = ij; rt_lpad = lp;
    rt_trap = tr; rt_mret = mr; rt_sret = sr; rt_tgt = tg;
    step();
  endtask

  initial begin
    idle_inputs();
    menv_lpe = 0; senv_lpe = 0; henv_lpe = 0; mstatus_i = '0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset elp", XLEN'(elp_o), 0);
    check("R1 reset fault", XLEN'(fault_o), 0);
    check("R1 reset status", mstatus_o, 0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_inputs();
      rt_valid = VEC[i][10]; rt_priv = VEC[i][9:8]; rt_virt = VEC[i][7];
      rt_ijmp = VEC[i][6]; rt_lpad = VEC[i][5];
      menv_lpe = VEC[i][4]; senv_lpe = VEC[i][3]; henv_lpe = VEC[i][2];
      step();
      check($sformatf("R2/R3/R4/R5/R11 table step %0d elp", i), XLEN'(elp_o), XLEN'(VEC[i][1]));
      check($sformatf("R5/R11 table step %0d fault", i), XLEN'(fault_o), XLEN'(VEC[i][0]));
      if (VEC[i][0])
        check($sformatf("R5 table step %0d cause", i), XLEN'(fault_cause_o), 18);
    end

    // R5: fault pulse lasts one cycle
    @(negedge clk); idle_inputs(); step();
    check("R5 fault pulse ends", XLEN'(fault_o), 0);

    // R6: trap to M saves expected state into bit 41
    menv_lpe = 0; senv_lpe = 1; henv_lpe = 0; mstatus_i = 64'h8;
    retire(2'b00, 1, 0, 0, 0, 0, 2'b00);
    check("R6 setup elp", XLEN'(elp_o), 1);
    retire(2'b00, 0, 0, 1, 0, 0, 2'b11);
    check("R6 trap M status", mstatus_o, 64'h8 | (64'h1 << MPB));
    check("R6 trap M elp", XLEN'(elp_o), 0);
    check("R6 trap M no fault", XLEN'(fault_o), 0);

    // R8: mret to U restores and clears bit 41
    mstatus_i = (64'h1 << MPB) | 64'h20;
    retire(2'b11, 0, 0, 0, 1, 0, 2'b00);
    check("R8 mret elp", XLEN'(elp_o), 1);
    check("R8 mret clears saved bit", mstatus_o, 64'h20);
    retire(2'b00, 0, 1, 0, 0, 0, 2'b00);
    check("R4 pad after mret", XLEN'(elp_o), 0);

    // R7: trap to S saves into bit 23
    mstatus_i = '0;
    retire(2'b00, 1, 0, 0, 0, 0, 2'b00);
    retire(2'b00, 0, 0, 1, 0, 0, 2'b01);
    check("R7 trap S status", mstatus_o, 64'h1 << SPB);
    check("R7 trap S elp", XLEN'(elp_o), 0);

    // R9: sret into U with senv off: stays none, bit cleared
    senv_lpe = 0; menv_lpe = 1;
    mstatus_i = (64'h1 << SPB) | 64'h2;
    retire(2'b01, 0, 0, 0, 0, 1, 2'b00);
    check("R9 sret disabled elp", XLEN'(elp_o), 0);
    check("R9 sret clears saved bit", mstatus_o, 64'h2);

    // R8: sret into U with senv on restores
    senv_lpe = 1;
    retire(2'b01, 0, 0, 0, 0, 1, 2'b00);
    check("R8 sret elp", XLEN'(elp_o), 1);
    check("R8 sret status", mstatus_o, 64'h2);
    retire(2'b00, 0, 1, 0, 0, 0, 2'b00);

    // R10: pass-through of untouched bits
    @(negedge clk); idle_inputs(); mstatus_i = 64'hA5A5_0000_1234_5678; step();
    check("R10 passthrough", mstatus_o, 64'hA5A5_0000_1234_5678);

    // R1: reset in mid-run while expected
    mstatus_i = '0;
    retire(2'b00, 1, 0, 0, 0, 0, 2'b00);
    @(negedge clk); idle_inputs(); rst = 1; step();
    check("R1 mid-run reset elp", XLEN'(elp_o), 0);
    @(negedge clk); rst = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule